// File: doc/BRIEF.md
# Hybrid Multicast/Broadcast Coherence Directory

This block keeps, for every line of a small shared-cache set, a record of which private caches hold a copy. Private caches announce a fill on the sharer-registration port and announce a dropped copy on the cleanup port. When the shared cache writes or evicts a line, it opens a coherence transaction on the transaction port. The directory then emits coherence messages on its outgoing channel, counts the acknowledgements that come back, and raises a one-cycle done pulse when the last expected one has arrived.

Each line entry holds a fixed number of sharer slots, set by the threshold parameter. Each slot has a valid bit and a cache number, and the entry also holds a copy counter. While the sharers fit in the slots, a transaction is multicast: one message goes to each recorded sharer, in slot order. A write sends updates and an eviction sends invalidates. When a sharer arrives and every slot is already taken, the entry sets an overflow mark. From then on every transaction on the line is a broadcast invalidate to all caches. The shared level is inclusive and write-through, so the directory never asks a private cache for data.

All four data ports are valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. A sender must keep valid and its payload steady until that edge. Transaction ready stays low from acceptance until the done pulse. Registration and cleanup ready stay low for the line that is in flight, or about to start. Registration ready also stays low whenever a cleanup is offered in the same cycle, so cleanup wins. A message on the coherence channel holds its destination, line and kind until the receiver accepts it.

Top module: `coh_dir`

## Requirements
- R1: After reset every entry is empty with no overflow, `txn_ready` is 1, and `coh_valid` and `done` are 0.
- R2: An accepted registration stores the cache number in the lowest-numbered free slot and increments the copy counter. Registering a cache that is already recorded changes nothing.
- R3: Without overflow, a transaction sends exactly one message per valid slot, in ascending slot order, to that slot's cache, on the addressed line. `coh_kind` is 0 (update) for a write (`txn_evict`=0) and 1 (invalidate) for an eviction (`txn_evict`=1).
- R4: A registration of a new cache when all slots are valid sets overflow and does not change the counter. Every later transaction on that line sends an invalidate (`coh_kind`=1) to caches 0 to N_CACHES-1 in ascending order, whatever the value of `txn_evict`.
- R5: The expected acknowledgement count is the copy counter without overflow and N_CACHES with overflow. `done` pulses for one cycle, with `done_line` giving the line, only after that many `ack_valid`/`ack_ready` transfers. A multicast with no sharers completes without sending any message.
- R6: Completing a broadcast, or a multicast eviction, leaves the entry empty with overflow cleared. A multicast update leaves the entry as it was.
- R7: A cleanup scans the slots in ascending order and clears the first valid slot whose cache number matches, then decrements the counter. With no match the entry and the counter are unchanged, so the counter never goes below zero.
- R8: From acceptance to the done pulse `txn_ready` is 0. Registration and cleanup ready are 0 for the pending line and stay 1 for the other lines.
- R9: While `coh_valid` is 1 and `coh_ready` is 0, the message on the coherence channel stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | Shared cache offers a coherence transaction |
| txn_ready | output | 1 | Directory can accept a transaction |
| txn_line | input | LINE_W | Line of the transaction |
| txn_evict | input | 1 | 0 = write (update), 1 = eviction (invalidate) |
| rd_valid | input | 1 | Private cache reports a fill |
| rd_ready | output | 1 | Registration accepted this cycle |
| rd_cache | input | ID_W | Cache number of the filler |
| rd_line | input | LINE_W | Line that was filled |
| cln_valid | input | 1 | Private cache reports a dropped copy |
| cln_ready | output | 1 | Cleanup accepted this cycle |
| cln_cache | input | ID_W | Cache number dropping the copy |
| cln_line | input | LINE_W | Line dropped |
| coh_valid | output | 1 | Coherence message offered |
| coh_ready | input | 1 | Target network accepts the message |
| coh_dest | output | ID_W | Destination cache |
| coh_line | output | LINE_W | Line concerned |
| coh_kind | output | 1 | 0 = update, 1 = invalidate |
| ack_valid | input | 1 | One coherence acknowledgement offered |
| ack_ready | output | 1 | Acknowledgement accepted |
| done | output | 1 | One-cycle completion pulse |
| done_line | output | LINE_W | Line whose transaction completed |

## Verification
The assertions assume that each coherence message is answered by exactly one acknowledgement, and that no acknowledgement arrives without a message before it. They also assume that line and cache numbers stay below N_LINES and N_CACHES, apart from the deliberate unmatched cleanup number, and that every sender holds its payload while valid is high. The bench answers only messages it has already received, one acknowledgement per message, and throttles `coh_ready` and `ack_valid` on fixed patterns. It draws line and cache numbers only from the legal ranges, apart from cache number 3, which the bench uses as a cleanup that matches no slot.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic {
    MSG_UPDATE = 1'b0,
    MSG_INVAL  = 1'b1
  } msg_e;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SEND,
    ENG_WAIT,
    ENG_DONE
  } eng_e;
endpackage

// File: rtl/coh_dir_entry.sv
module coh_dir_entry #(
  parameter int TH    = 2,
  parameter int ID_W  = 2,
  parameter int CNT_W = 2,
  localparam int TI_W = (TH > 1) ? $clog2(TH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               add_en,
  input  logic [ID_W-1:0]    add_id,
  input  logic               cln_en,
  input  logic [ID_W-1:0]    cln_id,
  input  logic               clr_en,
  output logic [TH-1:0]      slot_v,
  output logic [TH*ID_W-1:0] slot_ids,
  output logic [CNT_W-1:0]   copies,
  output logic               ovf
);
  logic            dup_hit;
  logic            free_found;
  logic [TI_W-1:0] free_idx;
  logic            cln_hit;
  logic [TI_W-1:0] cln_idx;

  // Slot scans: duplicate detection, first free slot, first matching slot.
  always_comb begin
    dup_hit    = 1'b0;
    free_found = 1'b0;
    free_idx   = '0;
    cln_hit    = 1'b0;
    cln_idx    = '0;
    for (int i = 0; i < TH; i++) begin
      if (slot_v[i] && slot_ids[i*ID_W +: ID_W] == add_id)
        dup_hit = 1'b1;
      if (!slot_v[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = TI_W'(i);
      end
      if (slot_v[i] && slot_ids[i*ID_W +: ID_W] == cln_id && !cln_hit) begin
        cln_hit = 1'b1;
        cln_idx = TI_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_en) begin
      slot_v   <= '0;
      slot_ids <= '0;
      copies   <= '0;
      ovf      <= 1'b0;
    end else if (cln_en) begin
      if (cln_hit) begin
        slot_v[cln_idx] <= 1'b0;
        copies          <= copies - 1'b1;
      end
    end else if (add_en && !ovf && !dup_hit) begin
      if (free_found) begin
        slot_v[free_idx]                   <= 1'b1;
        slot_ids[free_idx*ID_W +: ID_W]    <= add_id;
        copies                             <= copies + 1'b1;
      end else begin
        ovf <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/coh_dir_engine.sv
module coh_dir_engine
  import coh_dir_pkg::*;
#(
  parameter int N_CACHES = 3,
  parameter int TH       = 2,
  parameter int ID_W     = 2,
  parameter int LINE_W   = 1,
  parameter int CNT_W    = 2,
  localparam int ACK_W   = $clog2(N_CACHES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LINE_W-1:0]  start_line,
  input  logic               start_evict,
  input  logic [TH-1:0]      snap_v,
  input  logic [TH*ID_W-1:0] snap_ids,
  input  logic [CNT_W-1:0]   snap_copies,
  input  logic               snap_ovf,
  output logic               idle,
  output logic [LINE_W-1:0]  pend_line,
  output logic               coh_valid,
  input  logic               coh_ready,
  output logic [ID_W-1:0]    coh_dest,
  output logic               coh_kind,
  input  logic               ack_valid,
  output logic               ack_ready,
  output logic               done,
  output logic               clr_en
);
  eng_e               state;
  logic [TH-1:0]      sv;
  logic [TH*ID_W-1:0] sids;
  logic               bcast;
  logic               evict;
  logic [ACK_W-1:0]   cnt;
  logic [ID_W-1:0]    idx;
  logic               mc_v;
  logic [ID_W-1:0]    mc_id;
  logic [ID_W-1:0]    last_idx;
  logic               advance;

  always_comb begin
    mc_v  = 1'b0;
    mc_id = '0;
    for (int i = 0; i < TH; i++) begin
      if (idx == ID_W'(i)) begin
        mc_v  = sv[i];
        mc_id = sids[i*ID_W +: ID_W];
      end
    end
  end

  assign last_idx  = bcast ? ID_W'(N_CACHES - 1) : ID_W'(TH - 1);
  assign coh_valid = (state == ENG_SEND) && (bcast || mc_v);
  assign coh_dest  = bcast ? idx : mc_id;
  assign coh_kind  = (bcast || evict) ? MSG_INVAL : MSG_UPDATE;
  assign advance   = !coh_valid || coh_ready;
  assign idle      = (state == ENG_IDLE);
  assign ack_ready = !idle && (cnt != '0);
  assign done      = (state == ENG_DONE);
  assign clr_en    = done && (bcast || evict);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      sv        <= '0;
      sids      <= '0;
      bcast     <= 1'b0;
      evict     <= 1'b0;
      cnt       <= '0;
      idx       <= '0;
      pend_line <= '0;
    end else begin
      if (ack_valid && ack_ready)
        cnt <= cnt - 1'b1;
      case (state)
        ENG_IDLE: begin
          if (start) begin
            state     <= ENG_SEND;
            sv        <= snap_v;
            sids      <= snap_ids;
            bcast     <= snap_ovf;
            evict     <= start_evict;
            pend_line <= start_line;
            idx       <= '0;
            cnt       <= snap_ovf ? ACK_W'(N_CACHES) : ACK_W'(snap_copies);
          end
        end
        ENG_SEND: begin
          if (advance) begin
            if (idx == last_idx) state <= ENG_WAIT;
            else                 idx   <= idx + 1'b1;
          end
        end
        ENG_WAIT: begin
          if (cnt == '0) state <= ENG_DONE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coh_dir.sv
module coh_dir
  import coh_dir_pkg::*;
#(
  parameter int N_CACHES = 3,
  parameter int N_LINES  = 2,
  parameter int TH       = 2,
  localparam int ID_W    = (N_CACHES > 1) ? $clog2(N_CACHES) : 1,
  localparam int LINE_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1,
  localparam int CNT_W   = $clog2(TH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  output logic              txn_ready,
  input  logic [LINE_W-1:0] txn_line,
  input  logic              txn_evict,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ID_W-1:0]   rd_cache,
  input  logic [LINE_W-1:0] rd_line,
  input  logic              cln_valid,
  output logic              cln_ready,
  input  logic [ID_W-1:0]   cln_cache,
  input  logic [LINE_W-1:0] cln_line,
  output logic              coh_valid,
  input  logic              coh_ready,
  output logic [ID_W-1:0]   coh_dest,
  output logic [LINE_W-1:0] coh_line,
  output logic              coh_kind,
  input  logic              ack_valid,
  output logic              ack_ready,
  output logic              done,
  output logic [LINE_W-1:0] done_line
);
  logic [N_LINES*TH-1:0]      v_all;
  logic [N_LINES*TH*ID_W-1:0] ids_all;
  logic [N_LINES*CNT_W-1:0]   cp_all;
  logic [N_LINES-1:0]         ovf_all;

  logic               eng_idle;
  logic [LINE_W-1:0]  pend_line;
  logic               eng_clr;
  logic               start;
  logic               busy_rd;
  logic               busy_cln;
  logic [TH-1:0]      snap_v;
  logic [TH*ID_W-1:0] snap_ids;
  logic [CNT_W-1:0]   snap_cp;
  logic               snap_ovf;

  assign txn_ready = eng_idle;
  assign start     = txn_valid && txn_ready;

  // A line is locked while its transaction runs or is being accepted now.
  assign busy_rd  = (!eng_idle && rd_line == pend_line) || (start && rd_line == txn_line);
  assign busy_cln = (!eng_idle && cln_line == pend_line) || (start && cln_line == txn_line);
  assign cln_ready = !busy_cln;
  assign rd_ready  = !cln_valid && !busy_rd;

  always_comb begin
    snap_v   = '0;
    snap_ids = '0;
    snap_cp  = '0;
    snap_ovf = 1'b0;
    for (int l = 0; l < N_LINES; l++) begin
      if (txn_line == LINE_W'(l)) begin
        snap_v   = v_all[l*TH +: TH];
        snap_ids = ids_all[l*TH*ID_W +: TH*ID_W];
        snap_cp  = cp_all[l*CNT_W +: CNT_W];
        snap_ovf = ovf_all[l];
      end
    end
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic add_en;
    logic cln_en;
    logic clr_en;
    assign add_en = rd_valid && rd_ready && rd_line == LINE_W'(l);
    assign cln_en = cln_valid && cln_ready && cln_line == LINE_W'(l);
    assign clr_en = eng_clr && pend_line == LINE_W'(l);
    coh_dir_entry #(.TH(TH), .ID_W(ID_W), .CNT_W(CNT_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .add_en   (add_en),
      .add_id   (rd_cache),
      .cln_en   (cln_en),
      .cln_id   (cln_cache),
      .clr_en   (clr_en),
      .slot_v   (v_all[l*TH +: TH]),
      .slot_ids (ids_all[l*TH*ID_W +: TH*ID_W]),
      .copies   (cp_all[l*CNT_W +: CNT_W]),
      .ovf      (ovf_all[l])
    );
  end

  coh_dir_engine #(
    .N_CACHES(N_CACHES), .TH(TH), .ID_W(ID_W), .LINE_W(LINE_W), .CNT_W(CNT_W)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_line  (txn_line),
    .start_evict (txn_evict),
    .snap_v      (snap_v),
    .snap_ids    (snap_ids),
    .snap_copies (snap_cp),
    .snap_ovf    (snap_ovf),
    .idle        (eng_idle),
    .pend_line   (pend_line),
    .coh_valid   (coh_valid),
    .coh_ready   (coh_ready),
    .coh_dest    (coh_dest),
    .coh_kind    (coh_kind),
    .ack_valid   (ack_valid),
    .ack_ready   (ack_ready),
    .done        (done),
    .clr_en      (eng_clr)
  );

  assign coh_line  = pend_line;
  assign done_line = pend_line;
endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk #(
  parameter int N_LINES = 2,
  parameter int TH      = 2,
  parameter int ID_W    = 2,
  parameter int LINE_W  = 1,
  parameter int CNT_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     txn_valid,
  input logic                     txn_ready,
  input logic                     cln_valid,
  input logic                     cln_ready,
  input logic [LINE_W-1:0]        cln_line,
  input logic                     coh_valid,
  input logic                     coh_ready,
  input logic [ID_W-1:0]          coh_dest,
  input logic [LINE_W-1:0]        coh_line,
  input logic                     coh_kind,
  input logic                     done,
  input logic [N_LINES*CNT_W-1:0] cp_all
);
  // R9
  coh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coh_valid && !coh_ready |=> coh_valid && $stable(coh_dest) && $stable(coh_kind) && $stable(coh_line));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_ready |=> !txn_ready);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cln_valid && cln_ready && cln_line == '0 && cp_all[CNT_W-1:0] == '0 |=> cp_all[CNT_W-1:0] == '0);

  for (genvar l = 0; l < N_LINES; l++) begin : g_bound
    // R2
    copies_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cp_all[l*CNT_W +: CNT_W] <= CNT_W'(TH));
  end
endmodule

bind coh_dir coh_dir_chk #(
  .N_LINES(N_LINES), .TH(TH), .ID_W(ID_W), .LINE_W(LINE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
  .cln_valid(cln_valid), .cln_ready(cln_ready), .cln_line(cln_line),
  .coh_valid(coh_valid), .coh_ready(coh_ready), .coh_dest(coh_dest),
  .coh_line(coh_line), .coh_kind(coh_kind), .done(done), .cp_all(cp_all)
);

// File: tb/sim_coh_dir.sv
`timescale 1ns/1ps
module sim_coh_dir;
  localparam int NC = 3;
  localparam int NL = 2;
  localparam int TH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txn_valid = 0, txn_evict = 0, rd_valid = 0, cln_valid = 0;
  logic coh_ready = 0, ack_valid = 0;
  logic [0:0] txn_line = 0, rd_line = 0, cln_line = 0;
  logic [1:0] rd_cache = 0, cln_cache = 0;
  logic txn_ready, rd_ready, cln_ready, coh_valid, coh_kind, ack_ready, done;
  logic [1:0] coh_dest;
  logic [0:0] coh_line, done_line;

  coh_dir #(.N_CACHES(NC), .N_LINES(NL), .TH(TH)) u0 (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // bench model of the directory
  bit mv[NL][TH];
  int mid[NL][TH];
  bit movf[NL];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void m_add(int l, int c);
    int fr = -1;
    if (movf[l]) return;
    for (int i = 0; i < TH; i++) if (mv[l][i] && mid[l][i] == c) return;
    for (int i = TH - 1; i >= 0; i--) if (!mv[l][i]) fr = i;
    if (fr < 0) movf[l] = 1;
    else begin mv[l][fr] = 1; mid[l][fr] = c; end
  endfunction

  function automatic void m_cln(int l, int c);
    for (int i = 0; i < TH; i++)
      if (mv[l][i] && mid[l][i] == c) begin mv[l][i] = 0; return; end
  endfunction

  task automatic do_rd(int l, int c);
    @(negedge clk); rd_valid = 1; rd_line = l[0:0]; rd_cache = c[1:0]; #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 rd_valid = 0;
    m_add(l, c);
  endtask

  task automatic do_cln(int l, int c);
    @(negedge clk); cln_valid = 1; cln_line = l[0:0]; cln_cache = c[1:0]; #1;
    while (!cln_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 cln_valid = 0;
    m_cln(l, c);
  endtask

  task automatic txn_start(int l, int ev);
    @(negedge clk); txn_valid = 1; txn_line = l[0:0]; txn_evict = ev[0]; #1;
    while (!txn_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 txn_valid = 0;
  endtask

  task automatic txn_finish(int l, int ev);
    int ed[8]; int ek; int nexp = 0;
    int gd[8]; int gk[8]; int nrecv = 0; int nack = 0; int pend = 0;
    bit seen = 0; int t = 0;
    if (movf[l]) begin
      for (int c = 0; c < NC; c++) ed[nexp++] = c;
      ek = 1;
    end else begin
      for (int i = 0; i < TH; i++) if (mv[l][i]) ed[nexp++] = mid[l][i];
      ek = ev;
    end
    while (!seen && t < 300) begin
      @(negedge clk); t++;
      if (done) begin
        seen = 1;
        chk(done_line == l[0:0], "R5 done_line", int'(done_line), l);
        chk(nack == nexp, "R5 acks before done", nack, nexp);
        coh_ready = 0; ack_valid = 0;
      end else begin
        coh_ready = (t % 3 != 0);
        ack_valid = (pend > 0) && (t % 2 == 1);
        #1;
        if (coh_valid && coh_ready) begin
          if (nrecv < 8) begin gd[nrecv] = int'(coh_dest); gk[nrecv] = int'(coh_kind); end
          chk(coh_line == l[0:0], "R3 coh_line", int'(coh_line), l);
          nrecv++; pend++;
        end
        if (ack_valid && ack_ready) begin pend--; nack++; end
      end
    end
    chk(seen, "R5 done seen", int'(seen), 1);
    chk(nrecv == nexp, movf[l] ? "R4 message count" : "R3 message count", nrecv, nexp);
    for (int i = 0; i < nexp && i < nrecv; i++) begin
      chk(gd[i] == ed[i], movf[l] ? "R4 dest order" : "R3 dest order", gd[i], ed[i]);
      chk(gk[i] == ek, movf[l] ? "R4 kind" : "R3 kind", gk[i], ek);
    end
    if (movf[l] || ev != 0) begin
      // R6: entry emptied
      movf[l] = 0;
      for (int i = 0; i < TH; i++) mv[l][i] = 0;
    end
  endtask

  task automatic run_txn(int l, int ev);
    txn_start(l, ev);
    txn_finish(l, ev);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(txn_ready == 1, "R1 txn_ready", int'(txn_ready), 1);
    chk(coh_valid == 0, "R1 coh_valid", int'(coh_valid), 0);
    chk(done == 0, "R1 done", int'(done), 0);
    run_txn(0, 0); // R1/R5: empty entry completes without messages
    run_txn(1, 0);

    // R2 first free slot reuse after cleanup, duplicate ignored
    do_rd(1, 0); do_rd(1, 1); do_rd(1, 1); do_cln(1, 0); do_rd(1, 2);
    run_txn(1, 0); // R6: update keeps sharers, expect [2,1]
    run_txn(1, 0);
    run_txn(1, 1);
    run_txn(1, 0); // empty after eviction

    // R8/R9 stall and hold while the target network back-pressures
    do_rd(0, 1); do_rd(0, 2);
    coh_ready = 0;
    txn_start(0, 0);
    @(negedge clk); #1;
    chk(txn_ready == 0, "R8 txn_ready while busy", int'(txn_ready), 0);
    rd_valid = 1; rd_line = 0; rd_cache = 0; #1;
    chk(rd_ready == 0, "R8 rd same line stalled", int'(rd_ready), 0);
    rd_line = 1; #1;
    chk(rd_ready == 1, "R8 rd other line free", int'(rd_ready), 1);
    rd_valid = 0;
    cln_valid = 1; cln_line = 0; cln_cache = 1; #1;
    chk(cln_ready == 0, "R8 cln same line stalled", int'(cln_ready), 0);
    cln_valid = 0;
    chk(coh_valid == 1 && coh_dest == 1, "R9 first message", int'(coh_dest), 1);
    @(negedge clk); #1;
    chk(coh_valid == 1 && coh_dest == 1, "R9 message held", int'(coh_dest), 1);
    txn_finish(0, 0);
    run_txn(0, 1);

    // near-exhaustive sweep: line x sharer set x cleanup target
    for (int l = 0; l < NL; l++) begin
      for (int mask = 0; mask < 8; mask++) begin
        for (int cl = 0; cl < 4; cl++) begin
          for (int k = 0; k < NC; k++) begin
            int c = (cl % 2 == 1) ? (NC - 1 - k) : k;
            if (mask[c]) do_rd(l, c);
          end
          if (mask != 0) do_rd(l, (mask[0]) ? 0 : ((mask[1]) ? 1 : 2)); // R2 duplicate
          do_cln(l, cl);        // R7: cl=3 matches nothing
          do_cln(l, cl);        // R7: repeat cannot underflow
          run_txn(l, 0);        // R3/R4 write
          run_txn(l, 1);        // R6 eviction empties
          run_txn(l, 0);        // R6 check emptied: no messages
        end
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule